// File: doc/BRIEF.md
# Tiled Matrix Multiply Command Sequencer

This block turns one matrix multiply job into an ordered stream of tile commands for a downstream memory mover and multiply array. The left operand is held in memory transposed (K rows by M columns), the right operand is K rows by N columns, and the product is M rows by N columns. The sequencer walks output tiles and contraction tiles. It emits five command kinds: fetch a stationary tile, fetch a moving tile, multiply-accumulate, drain the accumulator to working memory, and store the result tile. Each command carries a byte address, the row and column base indices of the tile, and the tile extents.

A stationary tile is TILE_K rows by TILE_M columns of the transposed left operand (128 by 128 by default). A moving tile is TILE_K by TILE_N (128 by 512). An output tile is TILE_M by TILE_N. Output tile (m,n) covers rows m·TILE_M up to but not including (m+1)·TILE_M, and columns n·TILE_N up to but not including (n+1)·TILE_N. Within each output tile the contraction index runs innermost, and the first multiply of an accumulation clears the accumulator. A mode input picks one of two orderings. In plain ordering, both fetches sit inside the innermost loop. In hoisted ordering, each stationary tile is fetched once per (m,k) pair and is reused for every output column tile.

The controller is a single state machine. Its states are IDLE, STAT (fetch stationary), MOV (fetch moving), MAC, DRAIN, STORE, FINISH and REJECT. Its transitions are:
- IDLE to STAT on a start with legal dimensions.
- IDLE to REJECT on a start with illegal dimensions.
- STAT to MOV, and MOV to MAC, each on acceptance.
- MAC to DRAIN when the last k step is accepted. Otherwise MAC goes to STAT in plain mode, and in hoisted mode when the column tile is the last one. In hoisted mode with column tiles remaining, MAC goes to MOV.
- DRAIN to STORE on acceptance.
- STORE to FINISH after the final tile. Otherwise STORE goes to MOV in hoisted mode when column tiles remain in the row block, and to STAT in all other cases.
- FINISH to IDLE and REJECT to IDLE, each unconditionally.

Top module: `mm_tile_sequencer`

## Requirements
- R1: After reset, cmd_valid, done, err and busy are all 0.
- R2: A start is rejected if dim_m or dim_k is zero or not a multiple of 128, or if dim_n is zero or not a multiple of 512. A rejected start issues no command, drives done high for exactly the one cycle after the start edge, and sets err. err stays high until the next accepted start, which clears it.
- R3: Plain ordering (hoist_mode=0) issues the following sequence. For m, then n, then k (k innermost): stationary fetch (op 0), moving fetch (op 1), MAC (op 2). After the last k of each (m,n): DRAIN (op 3), then STORE (op 4).
- R4: Hoisted ordering (hoist_mode=1) issues the following sequence. For m, then k: one stationary fetch. Then, for each n: moving fetch and MAC. On the last k, each MAC is followed at once by DRAIN and STORE for that n.
- R5: cmd_clear is 1 on a MAC whose k index is 0 and 0 on every other command.
- R6: cmd_addr = base + row·stride + col·2, using the base and stride of the operand involved. The stationary fetch uses the left operand: row k·128, column m·128, extents 128×128. The moving fetch uses the right operand: row k·128, column n·512, extents 128×512. MAC, DRAIN and STORE use the output matrix: row m·128, column n·512, extents 128×512. cmd_row, cmd_col, cmd_rows and cmd_cols carry those values.
- R7: While cmd_valid is high and cmd_ready is low, the presented command stays unchanged. Exactly one command advances per cycle in which both are high.
- R8: done is high for exactly one cycle: the cycle right after the final STORE is accepted.
- R9: While busy is high, start is ignored, and changes on the dimension, address, stride and mode inputs do not alter the command stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job start pulse, sampled while idle |
| hoist_mode | input | 1 | 0 plain ordering, 1 hoisted stationary ordering |
| dim_m | input | DIM_W | Output rows M |
| dim_k | input | DIM_W | Contraction length K |
| dim_n | input | DIM_W | Output columns N |
| lhs_base | input | ADDR_W | Byte base of transposed left operand |
| rhs_base | input | ADDR_W | Byte base of right operand |
| out_base | input | ADDR_W | Byte base of result |
| lhs_stride | input | ADDR_W | Row stride in bytes, left operand |
| rhs_stride | input | ADDR_W | Row stride in bytes, right operand |
| out_stride | input | ADDR_W | Row stride in bytes, result |
| cmd_ready | input | 1 | Consumer accepts the command |
| cmd_valid | output | 1 | Command presented |
| cmd_op | output | 3 | 0 stationary, 1 moving, 2 MAC, 3 drain, 4 store |
| cmd_clear | output | 1 | Clear accumulator before this MAC |
| cmd_addr | output | ADDR_W | Tile byte address |
| cmd_row | output | DIM_W | Tile row base index |
| cmd_col | output | DIM_W | Tile column base index |
| cmd_rows | output | EXT_W | Tile row extent |
| cmd_cols | output | EXT_W | Tile column extent |
| busy | output | 1 | A job or its done/reject cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start had illegal dimensions |

## Verification
Jobs of one tile and of 2×2×2 tiles run in both orderings. This separates the loop nestings: a single tile gives the same stream in both modes, while multi-tile jobs differ in how many stationary fetches occur and where DRAIN and STORE fall. A 3×1×2 job with unequal strides and bases catches swapped indices or operands in the address arithmetic. Ready patterns that are constantly high, alternating and irregular expose loss or duplication of a command during stalls. Starts with zero and non-multiple dimensions, and a second start during a running job with changed inputs, check rejection and input latching.

// File: rtl/mm_seq_pkg.sv
package mm_seq_pkg;

    typedef enum logic [2:0] {
        OP_LOAD_STAT = 3'd0,
        OP_LOAD_MOV  = 3'd1,
        OP_MAC       = 3'd2,
        OP_DRAIN     = 3'd3,
        OP_STORE     = 3'd4
    } mm_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STAT,
        S_MOV,
        S_MAC,
        S_DRAIN,
        S_STORE,
        S_FINISH,
        S_REJECT
    } mm_state_e;

endpackage

// File: rtl/mm_dim_check.sv
module mm_dim_check #(
    parameter int DIM_W  = 16,
    parameter int TILE_M = 128,
    parameter int TILE_K = 128,
    parameter int TILE_N = 512
) (
    input  logic [DIM_W-1:0] dim_m,
    input  logic [DIM_W-1:0] dim_k,
    input  logic [DIM_W-1:0] dim_n,
    output logic             dims_ok,
    output logic [DIM_W-1:0] m_tiles,
    output logic [DIM_W-1:0] k_tiles,
    output logic [DIM_W-1:0] n_tiles
);
    localparam int NDIM = 3;

    logic [DIM_W-1:0] dims [NDIM];
    logic [DIM_W-1:0] cnts [NDIM];
    logic [NDIM-1:0]  ok_v;

    assign dims[0] = dim_m;
    assign dims[1] = dim_k;
    assign dims[2] = dim_n;

    // Tile sizes are powers of two, so legality is a low-bit test.
    for (genvar g = 0; g < NDIM; g++) begin : g_dim
        localparam int TS = (g == 0) ? TILE_M : ((g == 1) ? TILE_K : TILE_N);
        localparam int SH = $clog2(TS);
        assign ok_v[g] = (dims[g] != '0) && (dims[g][SH-1:0] == '0);
        assign cnts[g] = dims[g] >> SH;
    end

    assign dims_ok = &ok_v;
    assign m_tiles = cnts[0];
    assign k_tiles = cnts[1];
    assign n_tiles = cnts[2];

endmodule

// File: rtl/mm_addr_calc.sv
module mm_addr_calc #(
    parameter int ADDR_W     = 32,
    parameter int DIM_W      = 16,
    parameter int ELEM_BYTES = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [DIM_W-1:0]  row,
    input  logic [DIM_W-1:0]  col,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] row_off;
    logic [ADDR_W-1:0] col_off;

    assign row_off = ADDR_W'(row) * stride;
    assign col_off = ADDR_W'(col) * ADDR_W'(ELEM_BYTES);
    assign addr    = base + row_off + col_off;

endmodule

// File: rtl/mm_tile_sequencer.sv
module mm_tile_sequencer
    import mm_seq_pkg::*;
#(
    parameter int DIM_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int ELEM_BYTES = 2,
    parameter int TILE_M     = 128,
    parameter int TILE_K     = 128,
    parameter int TILE_N     = 512,
    parameter int EXT_W      = $clog2(TILE_N) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              hoist_mode,
    input  logic [DIM_W-1:0]  dim_m,
    input  logic [DIM_W-1:0]  dim_k,
    input  logic [DIM_W-1:0]  dim_n,
    input  logic [ADDR_W-1:0] lhs_base,
    input  logic [ADDR_W-1:0] rhs_base,
    input  logic [ADDR_W-1:0] out_base,
    input  logic [ADDR_W-1:0] lhs_stride,
    input  logic [ADDR_W-1:0] rhs_stride,
    input  logic [ADDR_W-1:0] out_stride,
    input  logic              cmd_ready,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic              cmd_clear,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DIM_W-1:0]  cmd_row,
    output logic [DIM_W-1:0]  cmd_col,
    output logic [EXT_W-1:0]  cmd_rows,
    output logic [EXT_W-1:0]  cmd_cols,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int SH_M = $clog2(TILE_M);
    localparam int SH_K = $clog2(TILE_K);
    localparam int SH_N = $clog2(TILE_N);

    mm_state_e state, state_nxt;

    logic              dims_ok;
    logic [DIM_W-1:0]  m_tiles, k_tiles, n_tiles;
    logic [DIM_W-1:0]  m_cnt_q, k_cnt_q, n_cnt_q;
    logic [DIM_W-1:0]  m_idx, k_idx, n_idx;
    logic              mode_q, err_q;
    logic [ADDR_W-1:0] lhs_base_q, rhs_base_q, out_base_q;
    logic [ADDR_W-1:0] lhs_stride_q, rhs_stride_q, out_stride_q;
    logic              m_last, k_last, n_last, fire;
    logic [ADDR_W-1:0] sel_base, sel_stride;

    mm_dim_check #(
        .DIM_W (DIM_W),
        .TILE_M(TILE_M),
        .TILE_K(TILE_K),
        .TILE_N(TILE_N)
    ) i_dim_check (
        .dim_m  (dim_m),
        .dim_k  (dim_k),
        .dim_n  (dim_n),
        .dims_ok(dims_ok),
        .m_tiles(m_tiles),
        .k_tiles(k_tiles),
        .n_tiles(n_tiles)
    );

    mm_addr_calc #(
        .ADDR_W    (ADDR_W),
        .DIM_W     (DIM_W),
        .ELEM_BYTES(ELEM_BYTES)
    ) i_addr_calc (
        .base  (sel_base),
        .stride(sel_stride),
        .row   (cmd_row),
        .col   (cmd_col),
        .addr  (cmd_addr)
    );

    assign m_last = (m_idx == m_cnt_q - DIM_W'(1));
    assign k_last = (k_idx == k_cnt_q - DIM_W'(1));
    assign n_last = (n_idx == n_cnt_q - DIM_W'(1));
    assign fire   = cmd_valid && cmd_ready;

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:   if (start) state_nxt = dims_ok ? S_STAT : S_REJECT;
            S_STAT:   if (fire) state_nxt = S_MOV;
            S_MOV:    if (fire) state_nxt = S_MAC;
            S_MAC: begin
                if (fire) begin
                    if (k_last)                 state_nxt = S_DRAIN;
                    else if (mode_q && !n_last) state_nxt = S_MOV;
                    else                        state_nxt = S_STAT;
                end
            end
            S_DRAIN:  if (fire) state_nxt = S_STORE;
            S_STORE: begin
                if (fire) begin
                    if (n_last && m_last)       state_nxt = S_FINISH;
                    else if (mode_q && !n_last) state_nxt = S_MOV;
                    else                        state_nxt = S_STAT;
                end
            end
            S_FINISH: state_nxt = S_IDLE;
            S_REJECT: state_nxt = S_IDLE;
            default:  state_nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // Job configuration and loop indices
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_idx <= '0; k_idx <= '0; n_idx <= '0;
            m_cnt_q <= '0; k_cnt_q <= '0; n_cnt_q <= '0;
            mode_q <= 1'b0; err_q <= 1'b0;
            lhs_base_q <= '0; rhs_base_q <= '0; out_base_q <= '0;
            lhs_stride_q <= '0; rhs_stride_q <= '0; out_stride_q <= '0;
        end else if (state == S_IDLE) begin
            if (start) begin
                err_q        <= !dims_ok;
                m_idx        <= '0; k_idx <= '0; n_idx <= '0;
                m_cnt_q      <= m_tiles;
                k_cnt_q      <= k_tiles;
                n_cnt_q      <= n_tiles;
                mode_q       <= hoist_mode;
                lhs_base_q   <= lhs_base;
                rhs_base_q   <= rhs_base;
                out_base_q   <= out_base;
                lhs_stride_q <= lhs_stride;
                rhs_stride_q <= rhs_stride;
                out_stride_q <= out_stride;
            end
        end else if (fire && state == S_MAC && !k_last) begin
            if (mode_q) begin
                if (n_last) begin
                    n_idx <= '0;
                    k_idx <= k_idx + DIM_W'(1);
                end else begin
                    n_idx <= n_idx + DIM_W'(1);
                end
            end else begin
                k_idx <= k_idx + DIM_W'(1);
            end
        end else if (fire && state == S_STORE) begin
            if (n_last) begin
                n_idx <= '0;
                k_idx <= '0;
                m_idx <= m_idx + DIM_W'(1);
            end else begin
                n_idx <= n_idx + DIM_W'(1);
                if (!mode_q) k_idx <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        cmd_valid  = 1'b0;
        cmd_op     = OP_LOAD_STAT;
        cmd_clear  = 1'b0;
        cmd_row    = m_idx << SH_M;
        cmd_col    = n_idx << SH_N;
        cmd_rows   = EXT_W'(TILE_M);
        cmd_cols   = EXT_W'(TILE_N);
        sel_base   = out_base_q;
        sel_stride = out_stride_q;
        unique case (state)
            S_STAT: begin
                cmd_valid  = 1'b1;
                cmd_op     = OP_LOAD_STAT;
                cmd_row    = k_idx << SH_K;
                cmd_col    = m_idx << SH_M;
                cmd_rows   = EXT_W'(TILE_K);
                cmd_cols   = EXT_W'(TILE_M);
                sel_base   = lhs_base_q;
                sel_stride = lhs_stride_q;
            end
            S_MOV: begin
                cmd_valid  = 1'b1;
                cmd_op     = OP_LOAD_MOV;
                cmd_row    = k_idx << SH_K;
                cmd_rows   = EXT_W'(TILE_K);
                sel_base   = rhs_base_q;
                sel_stride = rhs_stride_q;
            end
            S_MAC: begin
                cmd_valid  = 1'b1;
                cmd_op     = OP_MAC;
                cmd_clear  = (k_idx == '0);
            end
            S_DRAIN: begin
                cmd_valid  = 1'b1;
                cmd_op     = OP_DRAIN;
            end
            S_STORE: begin
                cmd_valid  = 1'b1;
                cmd_op     = OP_STORE;
            end
            default: ;
        endcase
    end

    assign busy = (state != S_IDLE);
    assign done = (state == S_FINISH) || (state == S_REJECT);
    assign err  = err_q;

    // R7: a stalled command is held unchanged
    p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr)
                                    && $stable(cmd_clear) && $stable(cmd_row) && $stable(cmd_col));

    // R5: clear flag appears only on multiply commands
    p_clear_on_mac_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_clear |-> cmd_op == OP_MAC);

    // R8: completion follows an accepted store
    p_done_after_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && !err |-> $past(cmd_valid && cmd_ready && cmd_op == OP_STORE));

    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: a rejected job never issues commands
    p_reject_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !cmd_valid);

    // R9: no command without an active job
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid && !done);

endmodule

// File: tb/test_mm_tile_sequencer.sv
module test_mm_tile_sequencer;

    localparam int TM = 128;
    localparam int TK = 128;
    localparam int TN = 512;

    typedef struct packed {
        logic [2:0]  op;
        logic        clr;
        logic [31:0] addr;
        logic [15:0] row;
        logic [15:0] col;
        logic [9:0]  rows;
        logic [9:0]  cols;
    } cmd_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        hoist_mode = 1'b0;
    logic [15:0] dim_m = '0, dim_k = '0, dim_n = '0;
    logic [31:0] lhs_base = '0, rhs_base = '0, out_base = '0;
    logic [31:0] lhs_stride = '0, rhs_stride = '0, out_stride = '0;
    logic        cmd_ready = 1'b0;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic        cmd_clear;
    logic [31:0] cmd_addr;
    logic [15:0] cmd_row, cmd_col;
    logic [9:0]  cmd_rows, cmd_cols;
    logic        busy, done, err;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    cmd_t expq[$];
    string cur_tag = "R3";
    int    ready_mode = 0;
    bit    mon_en = 1'b0;
    bit    done_due = 1'b0;
    bit    done_seen = 1'b0;
    bit    prev_stall = 1'b0;
    cmd_t  prev_cmd;
    int    toggle = 0;

    always #5 clk = ~clk;

    mm_tile_sequencer i_mm_tile_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .hoist_mode(hoist_mode),
        .dim_m(dim_m), .dim_k(dim_k), .dim_n(dim_n),
        .lhs_base(lhs_base), .rhs_base(rhs_base), .out_base(out_base),
        .lhs_stride(lhs_stride), .rhs_stride(rhs_stride), .out_stride(out_stride),
        .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_clear(cmd_clear), .cmd_addr(cmd_addr), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .cmd_rows(cmd_rows), .cmd_cols(cmd_cols),
        .busy(busy), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    function automatic cmd_t mk(input int op, input bit clr, input logic [31:0] base,
                                input logic [31:0] stride, input int row, input int col,
                                input int rows, input int cols);
        cmd_t c;
        c.op   = 3'(op);
        c.clr  = clr;
        c.addr = base + 32'(row) * stride + 32'(col) * 32'd2;
        c.row  = 16'(row);
        c.col  = 16'(col);
        c.rows = 10'(rows);
        c.cols = 10'(cols);
        return c;
    endfunction

    task automatic build(input bit hoist);
        int mt = int'(dim_m) / TM;
        int kt = int'(dim_k) / TK;
        int nt = int'(dim_n) / TN;
        expq.delete();
        for (int m = 0; m < mt; m++) begin
            if (!hoist) begin
                for (int n = 0; n < nt; n++) begin
                    for (int k = 0; k < kt; k++) begin
                        expq.push_back(mk(0, 0, lhs_base, lhs_stride, k*TK, m*TM, TK, TM));
                        expq.push_back(mk(1, 0, rhs_base, rhs_stride, k*TK, n*TN, TK, TN));
                        expq.push_back(mk(2, k == 0, out_base, out_stride, m*TM, n*TN, TM, TN));
                    end
                    expq.push_back(mk(3, 0, out_base, out_stride, m*TM, n*TN, TM, TN));
                    expq.push_back(mk(4, 0, out_base, out_stride, m*TM, n*TN, TM, TN));
                end
            end else begin
                for (int k = 0; k < kt; k++) begin
                    expq.push_back(mk(0, 0, lhs_base, lhs_stride, k*TK, m*TM, TK, TM));
                    for (int n = 0; n < nt; n++) begin
                        expq.push_back(mk(1, 0, rhs_base, rhs_stride, k*TK, n*TN, TK, TN));
                        expq.push_back(mk(2, k == 0, out_base, out_stride, m*TM, n*TN, TM, TN));
                        if (k == kt - 1) begin
                            expq.push_back(mk(3, 0, out_base, out_stride, m*TM, n*TN, TM, TN));
                            expq.push_back(mk(4, 0, out_base, out_stride, m*TM, n*TN, TM, TN));
                        end
                    end
                end
            end
        end
    endtask

    // Reference comparison, every falling edge
    always @(negedge clk) begin
        if (mon_en) begin
            cmd_t got;
            bit   pop;
            got = {cmd_op, cmd_clear, cmd_addr, cmd_row, cmd_col, cmd_rows, cmd_cols};
            // R8: done exactly in the cycle after the final store
            check(done == done_due, "R8", "done pulse", done, done_due);
            if (done_due && done) done_seen = 1'b1;
            done_due = 1'b0;
            if (cmd_valid) begin
                if (expq.size() == 0) begin
                    check(1'b0, cur_tag, "unexpected command", got.op, 7);
                end else begin
                    check(got.op == expq[0].op, cur_tag, "op order", got.op, expq[0].op);
                    check(got.clr == expq[0].clr, "R5", "clear flag", got.clr, expq[0].clr);
                    check({got.addr, got.row, got.col, got.rows, got.cols} ==
                          {expq[0].addr, expq[0].row, expq[0].col, expq[0].rows, expq[0].cols},
                          "R6", "address/extents", got.addr, expq[0].addr);
                end
                if (prev_stall)
                    check(got == prev_cmd, "R7", "held while stalled", got.addr, prev_cmd.addr);
            end
            case (ready_mode)
                0: cmd_ready = 1'b1;
                1: cmd_ready = ($urandom % 3) != 0;
                default: begin toggle++; cmd_ready = toggle[0]; end
            endcase
            pop = cmd_valid && cmd_ready;
            prev_stall = cmd_valid && !cmd_ready;
            prev_cmd = got;
            if (pop && expq.size() > 0) begin
                void'(expq.pop_front());
                if (expq.size() == 0) done_due = 1'b1;
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run_job(input bit hoist, input int m, input int k, input int n,
                           input int rmode, input string tag, input bit disturb);
        hoist_mode = hoist;
        dim_m = 16'(m); dim_k = 16'(k); dim_n = 16'(n);
        build(hoist);
        cur_tag = tag;
        ready_mode = rmode;
        done_seen = 1'b0;
        prev_stall = 1'b0;
        mon_en = 1'b1;
        pulse_start();
        if (disturb) begin
            repeat (4) @(negedge clk);
            // R9: change every input and restart mid-job
            start = 1'b1; hoist_mode = !hoist; dim_m = 16'd100;
            lhs_base = lhs_base + 32'h40; out_stride = out_stride + 32'h8;
            @(negedge clk); start = 1'b0;
        end
        while (!done_seen) @(negedge clk);
        check(expq.size() == 0, tag, "all commands issued", expq.size(), 0);
        check(err == 1'b0, disturb ? "R9" : "R2", "err after legal job", err, 0);
        @(negedge clk);
        mon_en = 1'b0;
        check(!busy && !cmd_valid, tag, "idle after done", busy, 0);
    endtask

    task automatic reject_job(input int m, input int k, input int n);
        dim_m = 16'(m); dim_k = 16'(k); dim_n = 16'(n);
        mon_en = 1'b0;
        cmd_ready = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(done == 1'b1, "R2", "reject done pulse", done, 1);
        check(err == 1'b1, "R2", "reject err", err, 1);
        check(cmd_valid == 1'b0, "R2", "reject no command", cmd_valid, 0);
        @(negedge clk);
        check(done == 1'b0, "R2", "reject done single", done, 0);
        check(err == 1'b1, "R2", "err sticky", err, 1);
        check(!busy && !cmd_valid, "R2", "reject idle", busy, 0);
    endtask

    initial begin
        lhs_base = 32'h1000_0000; rhs_base = 32'h2000_0000; out_base = 32'h3000_0000;
        lhs_stride = 32'd1024; rhs_stride = 32'd4096; out_stride = 32'd2048;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!cmd_valid && !done && !err && !busy, "R1", "reset outputs",
              {cmd_valid, done, err, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cmd_valid && !done && !err && !busy, "R1", "after reset release",
              {cmd_valid, done, err, busy}, 0);

        run_job(1'b0, 128, 128, 512, 0, "R3", 1'b0);
        run_job(1'b1, 128, 128, 512, 0, "R4", 1'b0);
        run_job(1'b0, 256, 256, 1024, 0, "R3", 1'b0);
        run_job(1'b1, 256, 256, 1024, 1, "R4", 1'b0);
        run_job(1'b0, 256, 256, 1024, 2, "R3", 1'b0);
        lhs_stride = 32'd768; rhs_stride = 32'd2560; out_stride = 32'd1536;
        run_job(1'b1, 384, 128, 1024, 2, "R4", 1'b0);
        run_job(1'b0, 384, 256, 512, 1, "R3", 1'b0);

        reject_job(100, 128, 512);
        reject_job(128, 0, 512);
        reject_job(128, 128, 256);
        // R2: a legal start clears err
        run_job(1'b1, 128, 256, 512, 1, "R4", 1'b0);

        // R9: start and inputs ignored while busy
        run_job(1'b0, 256, 256, 1024, 1, "R9", 1'b1);
        run_job(1'b1, 256, 256, 1024, 2, "R9", 1'b1);

        finish_run();
    end

endmodule